// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The router watches a wide bank of general-purpose input pins and turns up to eight of them into interrupt requests. Each channel picks one pin by its index. The chosen pin passes through a two-flop synchroniser. An optional inversion comes next, so a falling edge or an active-low level is seen as a rising edge or an active-high level. A programmable glitch filter follows. Each channel then works in one of two modes. In edge mode it sets a sticky pending flag. In level mode it passes the filtered level straight through. Every channel output is active-high, whatever the pin's own sense.

Software sets the router up through a flat 32-bit word port with one write strobe. There are two pin-select words, one mode word, one filter word, and a write-only acknowledge word that drops edge-pending flags. Reads are combinational, from a separate read address. The pad cells, the pin function multiplexer and the downstream interrupt controller sit outside this block.

Top module: `gpio_irq_router`

## Requirements
- R1: Channel n reads the pin whose index sits in an 8-bit field. Channels 0..3 use the word at address 0 and channels 4..7 use the word at address 1, with the field at bit (n mod 4)*8. A change on any other pin has no effect on that channel.
- R2: Words at addresses 0, 1, 2 and 3 read back what was written. In the mode word only bits [7:0] and [23:16] are kept and all other bits read 0. Address 4 is write-only and reads 0.
- R3: Mode word bit n set to 1 puts channel n in edge mode. Cleared to 0, it puts the channel in level mode.
- R4: Mode word bit 16+n set to 1 inverts channel n's pin, so a falling edge or a low level raises the output. Every output is active-high.
- R5: With the filter bypassed in level mode, the output follows a pin change after exactly two rising clock edges.
- R6: The filter word holds a 4-bit field for channel n at bit n*4. With value F>0, a change is accepted once the synchronised and inverted input has differed from the filtered value for 4*F consecutive cycles. The level output then changes 2+4F edges after the pin. Edge mode adds one more edge, giving 3+4F edges, or 3 edges when F is 0.
- R7: In level mode with F=1, an active pulse 3 cycles long never reaches the output, and a pulse 4 cycles long does.
- R8: In edge mode the pending flag stays set after the pin returns inactive. Writing 1 to bit n at address 4 clears channel n on the next edge. Zero bits in that write leave their channels untouched. A new edge in the same cycle as the clear wins.
- R9: Reset clears every word to 0. After reset every channel reads pin 0 in active-high level mode with the filter bypassed, so all outputs are low while pin 0 is low.
- R10: In level mode the output falls again once the pin returns to its inactive level, with the same latency as the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS (256) | Raw pin levels, asynchronous to clk |
| wr_en_i | input | 1 | Write strobe for the configuration words |
| wr_addr_i | input | 3 | Word address for writes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Word address for reads |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | NUM_CH (8) | Active-high interrupt output for each channel |

## Verification
The bench measures the exact edge count from a pin change to the output rise for each filter setting, both modes and both polarities. An off-by-one in the filter counter, or a missing synchroniser stage, shows up as a latency one edge off. It sends pulses one cycle short of and exactly at the filter window, so a filter that compares with the wrong limit lets a glitch through or swallows a valid pulse. Each channel's select field is placed at the top of the index range, with a neighbouring pin toggled as well, to catch swapped or shifted fields. The acknowledge word is written with only other bits set and then with the channel's own bit, to catch a clear that hits the wrong channel or fails to hold.

// File: rtl/gir_pkg.sv
package gir_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        A_SEL_LO = 3'd0,
        A_SEL_HI = 3'd1,
        A_MODE   = 3'd2,
        A_FILT   = 3'd3,
        A_ACK    = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 8,
    parameter int FLT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [2:0]                wr_addr_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic [2:0]                rd_addr_i,
    output logic [REG_W-1:0]          rd_data_o,
    output logic [NUM_CH*SEL_W-1:0]   sel_o,
    output logic [NUM_CH-1:0]         edge_o,
    output logic [NUM_CH-1:0]         inv_o,
    output logic [NUM_CH*FLT_W-1:0]   fsel_o,
    output logic [NUM_CH-1:0]         ack_o
);
    localparam int INV_POS = 16;
    localparam logic [REG_W-1:0] CH_BITS   = REG_W'((1 << NUM_CH) - 1);
    localparam logic [REG_W-1:0] MODE_MASK = CH_BITS | (CH_BITS << INV_POS);

    typedef struct packed {
        logic [REG_W-1:0] sel_lo;
        logic [REG_W-1:0] sel_hi;
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] filt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [2*REG_W-1:0] sel_all;

    always_comb begin
        cfg_d = cfg_q;
        ack_o = '0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_SEL_LO: cfg_d.sel_lo = wr_data_i;
                A_SEL_HI: cfg_d.sel_hi = wr_data_i;
                A_MODE:   cfg_d.mode   = wr_data_i & MODE_MASK;
                A_FILT:   cfg_d.filt   = wr_data_i;
                A_ACK:    ack_o        = wr_data_i[NUM_CH-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (reg_addr_e'(rd_addr_i))
            A_SEL_LO: rd_data_o = cfg_q.sel_lo;
            A_SEL_HI: rd_data_o = cfg_q.sel_hi;
            A_MODE:   rd_data_o = cfg_q.mode;
            A_FILT:   rd_data_o = cfg_q.filt;
            default:  rd_data_o = '0;
        endcase
    end

    assign sel_all = {cfg_q.sel_hi, cfg_q.sel_lo};
    assign sel_o   = sel_all[NUM_CH*SEL_W-1:0];
    assign edge_o  = cfg_q.mode[NUM_CH-1:0];
    assign inv_o   = cfg_q.mode[INV_POS +: NUM_CH];
    assign fsel_o  = cfg_q.filt[NUM_CH*FLT_W-1:0];

    // R2: the reserved mode bits can never be set by a write
    p_mode_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_MODE) |=> ((rd_addr_i != A_MODE) || ((rd_data_o & ~MODE_MASK) == '0)));
endmodule

// File: rtl/gir_channel.sv
module gir_channel #(
    parameter int NUM_PINS  = 256,
    parameter int SEL_W     = 8,
    parameter int FLT_W     = 4,
    parameter int FLT_SCALE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                edge_i,
    input  logic                inv_i,
    input  logic [FLT_W-1:0]    fsel_i,
    input  logic                ack_i,
    output logic                irq_o
);
    localparam int MAX_SPAN = ((1 << FLT_W) - 1) * FLT_SCALE;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             stable;
        logic             prev;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } ch_t;

    ch_t ch_d, ch_q;
    logic             picked, sensed, filt, rise, bypass;
    logic [CNT_W-1:0] span;

    always_comb begin
        ch_d   = ch_q;
        picked = pins_i[sel_i];
        ch_d.sync = {ch_q.sync[0], picked};
        sensed = ch_q.sync[1] ^ inv_i;
        bypass = (fsel_i == '0);
        span   = CNT_W'(fsel_i) * CNT_W'(FLT_SCALE);

        if (bypass) begin
            filt        = sensed;
            ch_d.stable = sensed;
            ch_d.cnt    = '0;
        end else begin
            filt = ch_q.stable;
            if (sensed == ch_q.stable) begin
                ch_d.cnt = '0;
            end else if (ch_q.cnt == span - CNT_W'(1)) begin
                ch_d.stable = sensed;
                ch_d.cnt    = '0;
            end else begin
                ch_d.cnt = ch_q.cnt + CNT_W'(1);
            end
        end

        ch_d.prev = filt;
        rise      = filt & ~ch_q.prev;
        ch_d.pend = (edge_i & rise) | (ch_q.pend & ~ack_i);
        irq_o     = edge_i ? ch_q.pend : filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // R8: a pending flag holds until acknowledged
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.pend && !ack_i) |=> ch_q.pend);

    // R8: an acknowledge without a coincident edge drops the flag
    p_pend_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(edge_i && rise)) |=> !ch_q.pend);

    // R7: the filtered value stays put until the full window has elapsed
    p_filt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && (sensed != ch_q.stable) && (ch_q.cnt != span - CNT_W'(1))) |=> $stable(ch_q.stable));

    // R3: in steady edge mode the output only rises after a detected edge
    p_edge_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && $past(edge_i) && $rose(irq_o)) |-> $past(rise));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_PINS  = 256,
    parameter int NUM_CH    = 8,
    parameter int FLT_SCALE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                wr_en_i,
    input  logic [2:0]          wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [2:0]          rd_addr_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic [NUM_CH-1:0]   irq_o
);
    localparam int SEL_W = $clog2(NUM_PINS);
    localparam int FLT_W = 4;

    logic [NUM_CH*SEL_W-1:0] sel_w;
    logic [NUM_CH-1:0]       edge_w, inv_w, ack_w;
    logic [NUM_CH*FLT_W-1:0] fsel_w;

    gir_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .FLT_W(FLT_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .sel_o(sel_w), .edge_o(edge_w), .inv_o(inv_w), .fsel_o(fsel_w), .ack_o(ack_w)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        gir_channel #(
            .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .FLT_W(FLT_W), .FLT_SCALE(FLT_SCALE)
        ) i_ch (
            .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
            .sel_i(sel_w[n*SEL_W +: SEL_W]),
            .edge_i(edge_w[n]), .inv_i(inv_w[n]),
            .fsel_i(fsel_w[n*FLT_W +: FLT_W]),
            .ack_i(ack_w[n]), .irq_o(irq_o[n])
        );
    end
endmodule

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] pins = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [7:0]   irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_router i_gpio_irq_router (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    // entry: {ch[2:0], pin[7:0], edge, inv, filt[3:0], latency[5:0]}
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 8'd5,   1'b0, 1'b0, 4'd0, 6'd2},
        {3'd1, 8'd100, 1'b1, 1'b0, 4'd0, 6'd3},
        {3'd2, 8'd17,  1'b0, 1'b1, 4'd0, 6'd2},
        {3'd3, 8'd200, 1'b1, 1'b1, 4'd1, 6'd7},
        {3'd4, 8'd255, 1'b0, 1'b0, 4'd7, 6'd30},
        {3'd5, 8'd64,  1'b1, 1'b0, 4'd2, 6'd11},
        {3'd7, 8'd254, 1'b0, 1'b1, 4'd3, 6'd14},
        {3'd6, 8'd1,   1'b1, 1'b1, 4'd7, 6'd31}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic config_ch(input int ch, input int pin, input bit e, input bit inv, input int f);
        logic [31:0] lo, hi;
        lo = (ch < 4) ? (32'(pin) << (8*ch)) : 32'd0;
        hi = (ch >= 4) ? (32'(pin) << (8*(ch-4))) : 32'd0;
        wr(3'd0, lo);
        wr(3'd1, hi);
        wr(3'd2, (32'(e) << ch) | (32'(inv) << (16+ch)));
        wr(3'd3, 32'(f) << (4*ch));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        step(3);
        // R9: reset state
        check(irq == 8'h00, "R9 irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        step(2);
        for (int a = 0; a < 5; a++) rd_check(3'(a), 32'd0, "R9 word reset");
        pins[0] = 1'b1;
        step(2);
        check(irq == 8'hFF, "R9 default selects pin 0 level", int'(irq), 255);
        pins[0] = 1'b0;
        step(2);

        // R2: readback and masking
        wr(3'd0, 32'hDEADBEEF); rd_check(3'd0, 32'hDEADBEEF, "R2 select lo readback");
        wr(3'd1, 32'h12345678); rd_check(3'd1, 32'h12345678, "R2 select hi readback");
        wr(3'd2, 32'hFFFFFFFF); rd_check(3'd2, 32'h00FF00FF, "R2 mode mask");
        wr(3'd3, 32'hA5A5A5A5); rd_check(3'd3, 32'hA5A5A5A5, "R2 filter readback");
        wr(3'd4, 32'hFFFFFFFF); rd_check(3'd4, 32'd0, "R2 ack reads zero");

        // R1 R3 R4 R6: vector table of latencies
        for (int v = 0; v < NV; v++) begin
            int ch, pin, f, lat, k;
            bit e, inv;
            {ch, pin, e, inv, f, lat} = {29'd0, VEC[v][22:20], 24'd0, VEC[v][19:12],
                                         VEC[v][11], VEC[v][10], 28'd0, VEC[v][9:6],
                                         26'd0, VEC[v][5:0]};
            pins = inv ? '1 : '0;
            config_ch(ch, pin, e, inv, f);
            step(40);
            wr(3'd4, 32'hFF);
            check(irq[ch] == 1'b0, "R4 idle output low", int'(irq[ch]), 0);
            pins[pin] = ~pins[pin];
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!irq[ch] && k < 80);
            check(k == lat, "R6 latency", k, lat);
        end

        // R8: sticky pending and acknowledge
        pins = '0;
        config_ch(1, 10, 1'b1, 1'b0, 0);
        step(5);
        wr(3'd4, 32'hFF);
        pins[10] = 1'b1;
        step(3);
        check(irq[1] == 1'b1, "R3 edge sets pending", int'(irq[1]), 1);
        pins[10] = 1'b0;
        step(5);
        check(irq[1] == 1'b1, "R8 pending stays after pin drops", int'(irq[1]), 1);
        wr(3'd4, 32'hFD);
        step(1);
        check(irq[1] == 1'b1, "R8 other ack bits no effect", int'(irq[1]), 1);
        wr(3'd4, 32'h02);
        check(irq[1] == 1'b0, "R8 ack clears", int'(irq[1]), 0);

        // R5 R10: level follow and drop
        config_ch(0, 3, 1'b0, 1'b0, 0);
        step(3);
        pins[3] = 1'b1;
        step(2);
        check(irq[0] == 1'b1, "R5 two edge latency", int'(irq[0]), 1);
        pins[3] = 1'b0;
        step(1);
        check(irq[0] == 1'b1, "R5 still synchronising", int'(irq[0]), 1);
        step(1);
        check(irq[0] == 1'b0, "R10 level drop", int'(irq[0]), 0);

        // R7: glitch filter boundary
        config_ch(2, 9, 1'b0, 1'b0, 1);
        step(10);
        begin
            bit seen = 0;
            pins[9] = 1'b1;
            for (int i = 0; i < 3; i++) begin @(negedge clk); seen |= irq[2]; end
            pins[9] = 1'b0;
            for (int i = 0; i < 15; i++) begin @(negedge clk); seen |= irq[2]; end
            check(seen == 1'b0, "R7 short pulse rejected", int'(seen), 0);
            seen = 0;
            pins[9] = 1'b1;
            for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= irq[2]; end
            pins[9] = 1'b0;
            for (int i = 0; i < 15; i++) begin @(negedge clk); seen |= irq[2]; end
            check(seen == 1'b1, "R7 full pulse accepted", int'(seen), 1);
        end

        // R1: neighbour pin does not reach the channel
        config_ch(4, 40, 1'b0, 1'b0, 0);
        step(3);
        pins[41] = 1'b1;
        step(5);
        check(irq[4] == 1'b0, "R1 neighbour pin ignored", int'(irq[4]), 0);
        pins[40] = 1'b1;
        step(2);
        check(irq[4] == 1'b1, "R1 selected pin", int'(irq[4]), 1);

        finish_run();
    end
endmodule